// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar of a real-time clock and raises an alarm when the clock reaches a programmed moment. The moment is a day of the month, an hour, a minute and a second. Each of the four is a two-digit BCD byte, and all four are packed into one 32-bit alarm register.

The calendar supplies its current time word, its current day-of-month byte and a one-cycle second tick. On a tick, if the alarm is armed and all four fields are equal, a sticky flag is set. The flag drives an interrupt line when interrupts are enabled.

Software disarms the alarm and then waits for a write-permitted status bit before it stores a new alarm value. It clears the flag before arming again, and the interrupt handler clears the flag once it has been served.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the alarm register reads 0, arm and interrupt-enable read 0, the flag and the interrupt read 0, and write-permitted reads 1.
- R2: The alarm register holds seconds in bits 7:0, minutes in bits 15:8, hours in bits 23:16 and day of month in bits 31:24. The current time word carries seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16. A hit requires all four bytes to be equal.
- R3: The flag is set only in the cycle after a tick that sees a hit while the alarm is armed. Without a tick, or while disarmed, it stays 0.
- R4: A hit sets the flag once. Further ticks with the time still equal do not set it again, even after it has been cleared.
- R5: Write-permitted reads 0 in every cycle the alarm is armed. It reads 1 one cycle after the arm bit falls, unless the alarm is re-armed in between.
- R6: A write to the alarm register while write-permitted reads 0 has no effect.
- R7: A flag clear resets the flag in the next cycle. A set that happens in the same cycle wins over the clear.
- R8: The interrupt output is high exactly when the flag and the interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse from the calendar, once per second |
| cur_time | input | 24 | Current time, BCD: hours, minutes, seconds |
| cur_day | input | 8 | Current day of month, BCD |
| alm_wr | input | 1 | Write strobe for the alarm register |
| alm_wdata | input | 32 | Alarm value to write |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_arm | input | 1 | Arm value written by ctl_wr |
| ctl_irq_en | input | 1 | Interrupt-enable value written by ctl_wr |
| flag_clr | input | 1 | Clears the alarm flag |
| alm_value | output | 32 | Current alarm register |
| armed | output | 1 | Alarm enabled |
| irq_en | output | 1 | Interrupt enabled |
| wr_ok | output | 1 | Alarm register may be written |
| alm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each with the fault it would expose:

- A time that differs from the alarm only in the day byte, or only in the hour byte. A comparator that drops a field would fire on it.
- A repeated tick at the same time after the flag is cleared. A level-sensitive design would fire again.
- A clear that lands on the same tick as a new hit. A design that favours the clear would lose the event.
- The exact cycle in which write-permitted rises after disarming, and an alarm write attempted while armed. A design with the wrong delay, or one that accepts writes while armed, shows up at the alarm register readback.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned STAMP_W    = FIELD_W * NUM_FIELDS;

    // Field order inside the packed alarm word, lowest byte first.
    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DAY  = 2'd3
    } alm_field_e;
endpackage

// File: rtl/alm_field_match.sv
module alm_field_match #(
    parameter int unsigned FW = 8,
    parameter int unsigned NF = 4
) (
    input  logic [FW*NF-1:0] alarm,
    input  logic [FW*NF-1:0] stamp,
    output logic             hit
);
    logic [NF-1:0] eq;

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign eq[i] = (alarm[i*FW +: FW] == stamp[i*FW +: FW]);
    end

    assign hit = &eq;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned FW = FIELD_W,
    parameter int unsigned NF = NUM_FIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FW*(NF-1)-1:0] cur_time,
    input  logic [FW-1:0]      cur_day,
    input  logic               alm_wr,
    input  logic [FW*NF-1:0]   alm_wdata,
    input  logic               ctl_wr,
    input  logic               ctl_arm,
    input  logic               ctl_irq_en,
    input  logic               flag_clr,
    output logic [FW*NF-1:0]   alm_value,
    output logic               armed,
    output logic               irq_en,
    output logic               wr_ok,
    output logic               alm_flag,
    output logic               irq
);
    localparam int unsigned AW = FW * NF;

    typedef struct packed {
        logic [AW-1:0] alm;
        logic          arm;
        logic          ie;
        logic          flag;
        logic          wok;
        logic          prev_hit;
    } state_t;

    state_t s_d, s_q;

    logic [AW-1:0] stamp;
    logic          hit;
    logic          arm_next;
    logic          fire;

    // Day byte sits above the time word, matching the alarm layout.
    assign stamp = {cur_day, cur_time};

    alm_field_match #(.FW(FW), .NF(NF)) u_match (
        .alarm (s_q.alm),
        .stamp (stamp),
        .hit   (hit)
    );

    always_comb begin
        s_d      = s_q;
        arm_next = ctl_wr ? ctl_arm : s_q.arm;
        fire     = sec_tick && s_q.arm && hit && !s_q.prev_hit;

        s_d.arm = arm_next;
        if (ctl_wr) begin
            s_d.ie = ctl_irq_en;
        end

        if (alm_wr && s_q.wok) begin
            s_d.alm = alm_wdata;
        end

        // Low as soon as arming is seen; high one cycle after disarm.
        s_d.wok = !s_q.arm && !arm_next;

        if (sec_tick) begin
            s_d.prev_hit = hit;
        end

        if (flag_clr) begin
            s_d.flag = 1'b0;
        end
        if (fire) begin
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.wok      <= 1'b1;
        end else begin
            s_q          <= s_d;
        end
    end

    assign alm_value = s_q.alm;
    assign armed     = s_q.arm;
    assign irq_en    = s_q.ie;
    assign wr_ok     = s_q.wok;
    assign alm_flag  = s_q.flag;
    assign irq       = s_q.flag & s_q.ie;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic          ctl_wr,
    input logic          ctl_arm,
    input logic          flag_clr,
    input logic [AW-1:0] alm_value,
    input logic          armed,
    input logic          irq_en,
    input logic          wr_ok,
    input logic          alm_flag,
    input logic          irq
);
    assert_no_set_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_flag && !sec_tick) |=> !alm_flag);

    assert_no_set_disarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_flag && !armed) |=> !alm_flag);

    assert_wrok_low_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !wr_ok);

    assert_wrok_after_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(armed) && !(ctl_wr && ctl_arm)) |=> wr_ok);

    assert_alarm_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(alm_value));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !sec_tick) |=> !alm_flag);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (alm_flag && irq_en));

    assert_irq_when_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) && irq_en |-> irq);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.AW(FW*NF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .ctl_wr    (ctl_wr),
    .ctl_arm   (ctl_arm),
    .flag_clr  (flag_clr),
    .alm_value (alm_value),
    .armed     (armed),
    .irq_en    (irq_en),
    .wr_ok     (wr_ok),
    .alm_flag  (alm_flag),
    .irq       (irq)
);

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [23:0] cur_time = '0;
    logic [7:0]  cur_day = '0;
    logic        alm_wr = 1'b0;
    logic [31:0] alm_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic        ctl_arm = 1'b0;
    logic        ctl_irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] alm_value;
    logic        armed, irq_en, wr_ok, alm_flag, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_alarm_match dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_time(cur_time), .cur_day(cur_day),
        .alm_wr(alm_wr), .alm_wdata(alm_wdata),
        .ctl_wr(ctl_wr), .ctl_arm(ctl_arm), .ctl_irq_en(ctl_irq_en),
        .flag_clr(flag_clr), .alm_value(alm_value), .armed(armed),
        .irq_en(irq_en), .wr_ok(wr_ok), .alm_flag(alm_flag), .irq(irq)
    );

    localparam logic [31:0] ALARM = 32'h15_23_59_58; // day 15, 23:59:58

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, release at the next one; outputs are then settled.
    task automatic tick_at(input logic [7:0] day, input logic [23:0] t, input logic clr);
        @(negedge clk);
        cur_day = day; cur_time = t; sec_tick = 1'b1; flag_clr = clr;
        @(negedge clk);
        sec_tick = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic ctl(input logic arm, input logic ie);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_arm = arm; ctl_irq_en = ie;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic write_alarm(input logic [31:0] v);
        @(negedge clk);
        alm_wr = 1'b1; alm_wdata = v;
        @(negedge clk);
        alm_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 alarm", alm_value, 32'h0);
        check("R1 armed", {31'b0, armed}, 32'h0);
        check("R1 ie", {31'b0, irq_en}, 32'h0);
        check("R1 flag", {31'b0, alm_flag}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 wr_ok", {31'b0, wr_ok}, 32'h1);
    endtask

    task automatic t_program_and_match();
        write_alarm(ALARM);
        check("R2 alarm stored", alm_value, ALARM);
        ctl(1'b1, 1'b1);
        check("R5 wr_ok low when armed", {31'b0, wr_ok}, 32'h0);
        // differs only in day
        tick_at(8'h16, 24'h23_59_58, 1'b0);
        check("R2 day mismatch", {31'b0, alm_flag}, 32'h0);
        // differs only in hour
        tick_at(8'h15, 24'h22_59_58, 1'b0);
        check("R2 hour mismatch", {31'b0, alm_flag}, 32'h0);
        // matching time without a tick
        @(negedge clk); cur_day = 8'h15; cur_time = 24'h23_59_58;
        @(negedge clk);
        check("R3 no tick no set", {31'b0, alm_flag}, 32'h0);
        tick_at(8'h15, 24'h23_59_58, 1'b0);
        check("R3 flag on hit", {31'b0, alm_flag}, 32'h1);
        check("R8 irq with ie", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_once();
        clear_flag();
        check("R7 clear", {31'b0, alm_flag}, 32'h0);
        check("R8 irq drops", {31'b0, irq}, 32'h0);
        tick_at(8'h15, 24'h23_59_58, 1'b0);
        check("R4 no refire", {31'b0, alm_flag}, 32'h0);
    endtask

    task automatic t_set_beats_clear();
        tick_at(8'h15, 24'h23_59_59, 1'b0);
        tick_at(8'h15, 24'h23_59_58, 1'b1);
        check("R7 set wins over clear", {31'b0, alm_flag}, 32'h1);
    endtask

    task automatic t_irq_enable();
        ctl(1'b1, 1'b0);
        check("R8 irq off with ie 0", {31'b0, irq}, 32'h0);
        check("R8 flag kept", {31'b0, alm_flag}, 32'h1);
        ctl(1'b1, 1'b1);
        check("R8 irq on with ie 1", {31'b0, irq}, 32'h1);
        clear_flag();
    endtask

    task automatic t_lock_and_disarm();
        write_alarm(32'h01_00_00_00);
        check("R6 write ignored when armed", alm_value, ALARM);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_arm = 1'b0; ctl_irq_en = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        check("R5 armed fell", {31'b0, armed}, 32'h0);
        check("R5 wr_ok still 0 same cycle", {31'b0, wr_ok}, 32'h0);
        @(negedge clk);
        check("R5 wr_ok one cycle later", {31'b0, wr_ok}, 32'h1);
        write_alarm(32'h02_10_20_30);
        check("R6 write accepted", alm_value, 32'h02_10_20_30);
    endtask

    task automatic t_disarmed_no_fire();
        tick_at(8'h01, 24'h00_00_00, 1'b0);
        tick_at(8'h02, 24'h10_20_30, 1'b0);
        check("R3 disarmed no set", {31'b0, alm_flag}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_and_match();
        t_once();
        t_set_beats_clear();
        t_irq_enable();
        t_lock_and_disarm();
        t_disarmed_no_fire();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule